// File: doc/BRIEF.md
# Bidirectional cascadable column data driver core

This block is the logic core of a display column driver. A line of pixel bits enters as a sequence of 6-bit words. Each word is pushed into six parallel lanes of 16-stage shift registers, which together hold 96 bits. A direction select decides which of the two 6-bit buses is the input and which carries the overflow out to the next driver in a chain. Because of this, any number of drivers can be chained to cover a line of any width, loaded from either end.

A strobe-controlled holding stage captures the full 96-bit line. An output stage then either passes the held bits to the 96 column outputs, forces every column low (blank), or forces every column high (polarity override).

The design is fully synchronous to `clk`. A word is accepted on every cycle in which `shift_en` is high. There is no back-pressure path: the shift register always takes the word, so a source may treat `shift_en` as a valid with an implied, permanently asserted ready. Each bidirectional bus is modelled as separate in, out and output-enable ports.

Top module: `colpix_driver`

## Requirements
- R1: A cycle with `rst` high clears the shift register and the held line to zero at that clock edge; afterwards, with `blank_n` and `pol_n` high, `col_out` reads all zeros, even after a strobe.
- R2: In a cycle with `shift_en` low, the shift register keeps its contents; repeated strobes then show an unchanged `col_out`.
- R3: With `dir_fwd` = 1 (forward), on each edge with `shift_en` high, `a_in` bit k lands at line bit k, and every line bit i moves to bit i+6. After 16 such shifts, the first word entered appears on `b_out`. In forward mode `b_oe` = 1, `a_oe` = 0 and `a_out` = 0.
- R4: With `dir_fwd` = 0 (reverse), on each edge with `shift_en` high, `b_in` bit k lands at line bit 90+k, and every line bit i moves to bit i−6. After 16 such shifts, the first word entered appears on `a_out`. In reverse mode `a_oe` = 1, `b_oe` = 0 and `b_out` = 0.
- R5: At a clock edge with `strobe` low, the held line takes the value the shift register holds just after that edge, including a word shifted in at the same edge.
- R6: At a clock edge with `strobe` high, the held line is not refreshed, however much shifting takes place.
- R7: While `blank_n` is low, all 96 bits of `col_out` are 0 in the same cycle, whatever `pol_n` and the held line are.
- R8: While `blank_n` is high and `pol_n` is low, all 96 bits of `col_out` are 1 in the same cycle.
- R9: While `blank_n` and `pol_n` are both high, `col_out` bit i equals held line bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and capture clock |
| rst | input | 1 | Synchronous clear, active high |
| shift_en | input | 1 | Shift one word on this edge |
| dir_fwd | input | 1 | 1: A bus in, B bus out; 0: B in, A out |
| strobe | input | 1 | Low: held line follows the shift register |
| blank_n | input | 1 | Low: all columns low |
| pol_n | input | 1 | Low (with blank_n high): all columns high |
| a_in | input | 6 | A bus input word |
| a_out | output | 6 | A bus cascade output word |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | 6 | B bus input word |
| b_out | output | 6 | B bus cascade output word |
| b_oe | output | 1 | B bus drive enable |
| col_out | output | 96 | Column logic levels |

## Verification
A corrupted stage in one lane is invisible at the columns until the next strobe-low cycle. It then shows at one bit, and that bit's position identifies both the lane and the stage. The same fault reaches the cascade bus only after enough further shifts carry it to the end stage, up to 16 cycles later. A wrong direction or a wrong stage order shows on the very next shift, as a misplaced word on the cascade bus. A fault in the holding stage shows in the cycle after a strobe edge, and a fault in the output priority shows in the same cycle that blank or polarity changes.

// File: rtl/colpix_pkg.sv
package colpix_pkg;
  localparam int unsigned COLPIX_LANES = 6;
  localparam int unsigned COLPIX_DEPTH = 16;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/colpix_lane.sv
// One bit lane of the line shift register; shifts toward higher stage
// index in forward mode, lower in reverse.
module colpix_lane #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             fwd,
  input  logic             head_in,
  input  logic             tail_in,
  output logic [DEPTH-1:0] stage_q,
  output logic [DEPTH-1:0] stage_d
);
  always_comb begin
    stage_d = stage_q;
    if (shift_en) begin
      if (fwd) stage_d = {stage_q[DEPTH-2:0], head_in};
      else     stage_d = {tail_in, stage_q[DEPTH-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end
endmodule

// File: rtl/colpix_cascade.sv
// Steers the end-stage word onto whichever bus is the output.
module colpix_cascade #(
  parameter int unsigned LANES = 6
) (
  input  logic             fwd,
  input  logic [LANES-1:0] head_word,
  input  logic [LANES-1:0] tail_word,
  output logic [LANES-1:0] a_out,
  output logic             a_oe,
  output logic [LANES-1:0] b_out,
  output logic             b_oe
);
  always_comb begin
    b_oe  = fwd;
    a_oe  = !fwd;
    b_out = fwd ? tail_word : '0;
    a_out = fwd ? '0 : head_word;
  end
endmodule

// File: rtl/colpix_hold.sv
// Strobe-gated holding stage for the full line.
module colpix_hold #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] line_d,
  output logic [WIDTH-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (!strobe) hold_q <= line_d;
  end
endmodule

// File: rtl/colpix_outstage.sv
// Column output priority: blank, then force-high, then held data.
module colpix_outstage #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             blank_n,
  input  logic             pol_n,
  input  logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] col_out
);
  always_comb begin
    if (!blank_n)    col_out = '0;
    else if (!pol_n) col_out = '1;
    else             col_out = hold_q;
  end
endmodule

// File: rtl/colpix_driver.sv
module colpix_driver
  import colpix_pkg::*;
#(
  parameter int unsigned LANES = COLPIX_LANES,
  parameter int unsigned DEPTH = COLPIX_DEPTH,
  localparam int unsigned WIDTH = LANES * DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             dir_fwd,
  input  logic             strobe,
  input  logic             blank_n,
  input  logic             pol_n,
  input  logic [LANES-1:0] a_in,
  output logic [LANES-1:0] a_out,
  output logic             a_oe,
  input  logic [LANES-1:0] b_in,
  output logic [LANES-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] col_out
);
  shift_dir_e                    dir;
  logic [LANES-1:0][DEPTH-1:0]   lane_q;
  logic [LANES-1:0][DEPTH-1:0]   lane_d;
  logic [WIDTH-1:0]              line_q;
  logic [WIDTH-1:0]              line_d;
  logic [WIDTH-1:0]              hold_q;

  assign dir = shift_dir_e'(dir_fwd);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    colpix_lane #(.DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .shift_en(shift_en),
      .fwd     (dir == DIR_FWD),
      .head_in (a_in[k]),
      .tail_in (b_in[k]),
      .stage_q (lane_q[k]),
      .stage_d (lane_d[k])
    );
    // Stage j of lane k is line bit LANES*j + k.
    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      assign line_q[LANES*j + k] = lane_q[k][j];
      assign line_d[LANES*j + k] = lane_d[k][j];
    end
  end

  colpix_cascade #(.LANES(LANES)) u_cascade (
    .fwd      (dir == DIR_FWD),
    .head_word(line_q[LANES-1:0]),
    .tail_word(line_q[WIDTH-1 -: LANES]),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe)
  );

  colpix_hold #(.WIDTH(WIDTH)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .line_d(line_d),
    .hold_q(hold_q)
  );

  colpix_outstage #(.WIDTH(WIDTH)) u_out (
    .blank_n(blank_n),
    .pol_n  (pol_n),
    .hold_q (hold_q),
    .col_out(col_out)
  );
endmodule

// File: rtl/colpix_checker.sv
module colpix_checker #(
  parameter int unsigned LANES = 6,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned WIDTH = LANES * DEPTH
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic             dir_fwd,
  input logic             strobe,
  input logic             blank_n,
  input logic             pol_n,
  input logic [LANES-1:0] a_in,
  input logic [LANES-1:0] a_out,
  input logic             a_oe,
  input logic [LANES-1:0] b_in,
  input logic [LANES-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] col_out,
  input logic [WIDTH-1:0] line_q,
  input logic [WIDTH-1:0] hold_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (line_q == '0 && hold_q == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(line_q));

  assert_fwd_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_fwd) |=> (line_q[LANES-1:0] == $past(a_in)));

  assert_fwd_cascade_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_fwd) |=> (!dir_fwd || (b_oe && !a_oe &&
      b_out == $past(line_q[WIDTH-LANES-1 -: LANES]))));

  assert_rev_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir_fwd) |=> (line_q[WIDTH-1 -: LANES] == $past(b_in)));

  assert_rev_cascade_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir_fwd) |=> (dir_fwd || (a_oe && !b_oe &&
      a_out == $past(line_q[2*LANES-1 -: LANES]))));

  assert_strobe_copy_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (hold_q == line_q));

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |=> $stable(hold_q));

  assert_blank_low_R7: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (col_out == '0));

  assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !pol_n) |-> (col_out == '1));

  assert_pass_data_R9: assert property (@(posedge clk) disable iff (rst)
    (blank_n && pol_n) |-> (col_out == hold_q));
endmodule

bind colpix_driver colpix_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .shift_en(shift_en),
  .dir_fwd (dir_fwd),
  .strobe  (strobe),
  .blank_n (blank_n),
  .pol_n   (pol_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .col_out (col_out),
  .line_q  (line_q),
  .hold_q  (hold_q)
);

// File: tb/colpix_driver_bench.sv
module colpix_driver_bench;
  localparam int LANES = 6;
  localparam int DEPTH = 16;
  localparam int WIDTH = LANES * DEPTH;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, shift_en, dir_fwd, strobe, blank_n, pol_n;
  logic [LANES-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;
  logic [WIDTH-1:0] col_out;

  colpix_driver u_colpix_driver (
    .clk(clk), .rst(rst), .shift_en(shift_en), .dir_fwd(dir_fwd),
    .strobe(strobe), .blank_n(blank_n), .pol_n(pol_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .col_out(col_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] exp_line = '0;
  logic [WIDTH-1:0] exp_hold = '0;

  function automatic logic [WIDTH-1:0] shifted(input logic [WIDTH-1:0] line,
      input logic fwd, input logic [LANES-1:0] a, input logic [LANES-1:0] b);
    return fwd ? {line[WIDTH-LANES-1:0], a} : {b, line[WIDTH-1:LANES]};
  endfunction

  function automatic logic [WIDTH-1:0] exp_cols(input logic bn, input logic pn);
    if (!bn) return '0;
    if (!pn) return '1;
    return exp_hold;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input logic r, input logic se, input logic fwd,
                      input logic stb, input logic bn, input logic pn,
                      input logic [LANES-1:0] a, input logic [LANES-1:0] b);
    logic [WIDTH-1:0] nl;
    logic [LANES-1:0] eb, ea;
    rst = r; shift_en = se; dir_fwd = fwd; strobe = stb;
    blank_n = bn; pol_n = pn; a_in = a; b_in = b;
    #1;
    eb = fwd ? exp_line[WIDTH-1 -: LANES] : '0;
    ea = fwd ? '0 : exp_line[LANES-1:0];
    chk(col_out === exp_cols(bn, pn), !bn ? "R7" : (!pn ? "R8" : "R9"),
        col_out, exp_cols(bn, pn));
    if (fwd) chk(b_out === eb && a_out === ea && b_oe === 1'b1 && a_oe === 1'b0,
                 "R3", {b_oe, a_oe, b_out, a_out}, {1'b1, 1'b0, eb, ea});
    else     chk(b_out === eb && a_out === ea && b_oe === 1'b0 && a_oe === 1'b1,
                 "R4", {b_oe, a_oe, b_out, a_out}, {1'b0, 1'b1, eb, ea});
    @(posedge clk);
    if (r) begin
      exp_line = '0;
      exp_hold = '0;
    end else begin
      nl = se ? shifted(exp_line, fwd, a, b) : exp_line;
      if (!stb) exp_hold = nl;
      exp_line = nl;
    end
    @(negedge clk);
  endtask

  logic [LANES-1:0] w [DEPTH];
  logic [WIDTH-1:0] saved;

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset clears everything
    step(1, 1, 1, 0, 1, 1, 6'h3f, 6'h3f);
    step(1, 0, 1, 1, 1, 1, 6'h15, 6'h2a);
    chk(col_out === '0, "R1", col_out, '0);
    step(0, 0, 1, 0, 1, 1, 6'h0, 6'h0);
    chk(col_out === '0, "R1", col_out, '0);

    // R3: forward load of one full line
    for (int i = 0; i < DEPTH; i++) begin
      w[i] = 6'($urandom);
      step(0, 1, 1, 1, 1, 1, w[i], 6'($urandom));
    end
    chk(b_out === w[0], "R3", {90'b0, b_out}, {90'b0, w[0]});
    step(0, 0, 1, 0, 1, 1, 6'h0, 6'h0);
    for (int j = 0; j < DEPTH; j++)
      chk(col_out[LANES*j +: LANES] === w[DEPTH-1-j], "R3",
          {90'b0, col_out[LANES*j +: LANES]}, {90'b0, w[DEPTH-1-j]});
    saved = col_out;

    // R6: shifting with strobe high leaves the columns alone
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 1, 1, 6'($urandom), 6'($urandom));
    chk(col_out === saved, "R6", col_out, saved);

    // R5: strobe low with a shift on the same edge captures the new word
    step(0, 1, 1, 0, 1, 1, 6'h2d, 6'h00);
    chk(col_out[LANES-1:0] === 6'h2d, "R5", {90'b0, col_out[5:0]}, {90'b0, 6'h2d});
    saved = col_out;

    // R2: no shift, repeated strobes, columns steady
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 1, 6'($urandom), 6'($urandom));
    chk(col_out === saved, "R2", col_out, saved);

    // R4: reverse load of one full line
    for (int i = 0; i < DEPTH; i++) begin
      w[i] = 6'($urandom);
      step(0, 1, 0, 1, 1, 1, 6'($urandom), w[i]);
    end
    chk(a_out === w[0], "R4", {90'b0, a_out}, {90'b0, w[0]});
    step(0, 0, 0, 0, 1, 1, 6'h0, 6'h0);
    for (int j = 0; j < DEPTH; j++)
      chk(col_out[LANES*j +: LANES] === w[j], "R4",
          {90'b0, col_out[LANES*j +: LANES]}, {90'b0, w[j]});

    // R7 / R8: output priority
    step(0, 0, 0, 1, 0, 1, 6'h0, 6'h0);
    chk(col_out === '0, "R7", col_out, '0);
    step(0, 0, 0, 1, 0, 0, 6'h0, 6'h0);
    chk(col_out === '0, "R7", col_out, '0);
    step(0, 0, 0, 1, 1, 0, 6'h0, 6'h0);
    chk(col_out === '1, "R8", col_out, '1);

    // Mixed random traffic against the bench model
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 200) == 0, ($urandom % 4) != 0, ($urandom % 8) != 0,
           ($urandom % 3) != 0, ($urandom % 10) != 0, ($urandom % 10) != 0,
           6'($urandom), 6'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule